// File: doc/BRIEF.md
# Complementary Dual-Stream Crossover Blender

This block merges two digitized versions of one analog input into a single sample stream at the fast rate. The fast stream is coarse (few bits) and arrives on every clock. The slow stream is fine (many bits), arrives once every `RATIO` clocks with a strobe, and has already passed through an analog anti-aliasing low-pass. The slow stream is brought to the fast rate, either by holding each sample or by a linear ramp between samples. The fast stream is scaled to the slow stream's weight and delayed so that both paths line up in time.

A first-order recursive low-pass runs on the aligned fast stream. Its output is subtracted from that same stream, which leaves a high-pass remainder. That remainder is added to the upsampled slow stream. Because the high-pass path is the fast stream minus its own low-pass copy, the two branches sum to unity gain at every frequency. The low-pass time constant is a power-of-two shift held in a register. Calibration writes it after reset so that the digital corner tracks the analog one. The final sum saturates to the output width.

Top module: `xover_blend`

## Requirements
- R1: While `rst_n` is low at a clock edge, `blend_out` reads 0 after that edge, and the coefficient register returns to shift 4 (k = 1/16).
- R2: The fast sample is taken as two's complement and weighted by 2^(SLOW_W−FAST_W), so fast code −3 on its own contributes −768 to the output.
- R3 (hold mode): A slow sample is taken only on a clock edge where `slow_vld` is high. `slow_in` has no effect at any other time. A new slow sample reaches `blend_out` two edges after the edge where it is presented.
- R4: A fast sample and a slow sample presented at the same edge reach `blend_out` together, two edges later. Nothing of either is visible after the first edge.
- R5: With the slow input at zero, a positive fast step X gives exactly X on its first output sample. After that the output never rises and never goes below zero, and it comes to exactly 0. With shift 4 the first three outputs are X, X·15/16 and X·225/256.
- R6: When both inputs hold the same value c (the slow input being c·2^(SLOW_W−FAST_W)), the output settles to exactly that value for any shift setting.
- R7: A coefficient write takes effect on the edge that follows it. With shift 0 the low-pass equals the previous aligned fast sample, so a fast step shows on the output for exactly one sample.
- R8: The sum saturates to the most positive or most negative output code instead of wrapping.
- R9: Changing the coefficient while the output is settled on equal constant inputs leaves the output exactly unchanged.
- R10 (linear mode, RATIO = 8): After a slow strobe, the upsampled value climbs from the previous sample to the new one in RATIO equal steps and then stays at the new value. A step from 0 to 8000 shows as 1000 on the third edge after the strobe edge, 4000 on the sixth and 8000 from the tenth edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock at the fast sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_in | input | FAST_W | Fast, coarse sample in two's complement, one per clock |
| slow_in | input | SLOW_W | Slow, fine sample in two's complement |
| slow_vld | input | 1 | High for one clock when `slow_in` carries a new slow sample |
| coef_wr | input | 1 | Loads `coef_in` into the low-pass shift register |
| coef_in | input | SH_W | Low-pass shift amount; the filter gain is 2^−shift |
| blend_out | output | OUT_W | Blended, saturated output sample in two's complement |

## Verification
Alignment and rate matching meet in a single cycle: a slow strobe and a fast step are presented at the same edge. The output is then judged on the edge before and on the edge after they must appear. A copy whose fast path is one stage short or long would show only one of the two contributions. Saturation and the high-pass transient also fall in one cycle: full-scale steps of the same sign are applied to both inputs together. The first output must then equal the rail exactly, which rules out both wrap-around and a clamp applied one stage too late.

// File: rtl/xb_pkg.sv
// Shared types for the crossover blender.
// Assumes: nothing beyond standard SystemVerilog.
package xb_pkg;

    // How the slow stream is brought to the fast rate.
    typedef enum logic {
        UP_HOLD   = 1'b0,
        UP_LINEAR = 1'b1
    } up_mode_e;

endpackage

// File: rtl/xb_delay.sv
// Fixed-length register chain that aligns the fast path with the slow path.
// Assumes: DEPTH >= 1; each stage is one clock.
module xb_delay #(
    parameter int W     = 18,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first stage captures the input
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d_in;
            end
        end else begin : g_next
            // later stages shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign d_out = stg[DEPTH-1];

endmodule

// File: rtl/xb_lerp.sv
// Linear upsampler: ramps from the previous slow sample to the new one
// in RATIO equal steps, then holds the new value until the next strobe.
// Assumes: RATIO is a power of two; strobes come no faster than RATIO clocks.
module xb_lerp #(
    parameter int W     = 18,
    parameter int RATIO = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_in,
    input  logic         s_vld,
    output logic [W-1:0] s_out
);

    localparam int L  = $clog2(RATIO);
    localparam int CW = $clog2(RATIO + 1);
    localparam int AW = W + L + 1;

    logic [W-1:0]  last_q;
    logic [W:0]    slope_q;
    logic [AW-1:0] acc_q;
    logic [CW-1:0] cnt_q;

    // select the integer part of the scaled accumulator
    function automatic logic [W-1:0] int_part(input logic [AW-1:0] a);
        return a[W+L-1:L];
    endfunction

    // restart the ramp on a strobe, otherwise step until RATIO steps are done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= '0;
            slope_q <= '0;
            acc_q   <= '0;
            cnt_q   <= '0;
        end else if (s_vld) begin
            last_q  <= s_in;
            slope_q <= {s_in[W-1], s_in} - {last_q[W-1], last_q};
            acc_q   <= {last_q[W-1], last_q, {L{1'b0}}};
            cnt_q   <= '0;
        end else if (cnt_q != CW'(RATIO)) begin
            acc_q   <= acc_q + {{(AW-W-1){slope_q[W]}}, slope_q};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign s_out = int_part(acc_q);

endmodule

// File: rtl/xb_lpf.sv
// First-order recursive low-pass y += (x - y) * 2^-shift with a loadable
// shift register. The state carries FRAC_W fraction bits and the output is
// rounded, so a constant input is reproduced exactly at steady state.
// Assumes: FRAC_W >= largest shift + 1.
module xb_lpf #(
    parameter int DW     = 18,
    parameter int SH_W   = 4,
    parameter int K_RST  = 4,
    parameter int FRAC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            coef_wr,
    input  logic [SH_W-1:0] coef_in,
    input  logic [DW-1:0]   x_in,
    output logic [DW+1:0]   lp_out,
    output logic [SH_W-1:0] coef_q
);

    localparam int SW = DW + 2 + FRAC_W;
    localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC_W - 1);

    logic signed [SW-1:0] st_q;
    logic signed [SW-1:0] target;
    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] step;

    // drop the fraction bits after rounding
    function automatic logic [DW+1:0] drop_frac(input logic [SW-1:0] v);
        return v[SW-1:FRAC_W];
    endfunction

    // coefficient register, written during calibration
    always_ff @(posedge clk) begin
        if (!rst_n)       coef_q <= SH_W'(K_RST);
        else if (coef_wr) coef_q <= coef_in;
    end

    // scaled error term toward the input
    always_comb begin
        target = {{2{x_in[DW-1]}}, x_in, {FRAC_W{1'b0}}};
        diff   = target - st_q;
        step   = diff >>> coef_q;
    end

    // filter state update
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_q + step;
    end

    assign lp_out = drop_frac(st_q + HALF);

endmodule

// File: rtl/xover_blend.sv
// Complementary crossover blender. The fast stream is scaled, delayed to the
// slow-path latency and split into low-pass and (fast - low-pass). The
// high-pass part is added to the upsampled slow stream, and the sum saturates.
// Assumes: one clock at the fast rate; slow strobes every RATIO clocks;
// OUT_W <= SLOW_W + 2; SLOW_W > FAST_W.
module xover_blend #(
    parameter int FAST_W = 10,
    parameter int SLOW_W = 18,
    parameter int OUT_W  = 18,
    parameter int RATIO  = 8,
    parameter int SH_W   = 4,
    parameter int K_RST  = 4,
    parameter xb_pkg::up_mode_e UP_MODE = xb_pkg::UP_HOLD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FAST_W-1:0] fast_in,
    input  logic [SLOW_W-1:0] slow_in,
    input  logic              slow_vld,
    input  logic              coef_wr,
    input  logic [SH_W-1:0]   coef_in,
    output logic [OUT_W-1:0]  blend_out
);

    localparam int SCALE  = SLOW_W - FAST_W;
    localparam int DLY    = (UP_MODE == xb_pkg::UP_LINEAR) ? RATIO + 1 : 1;
    localparam int FRAC_W = 2 ** SH_W;
    localparam int HPW    = SLOW_W + 2;
    localparam int SUMW   = SLOW_W + 3;
    localparam logic signed [SUMW-1:0] SAT_HI = SUMW'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [SUMW-1:0] SAT_LO = -SAT_HI - SUMW'(1);

    logic [SLOW_W-1:0]        x_s;
    logic [SLOW_W-1:0]        xd_w;
    logic [SLOW_W-1:0]        up_w;
    logic [HPW-1:0]           lp_w;
    logic signed [HPW-1:0]    hp_w;
    logic signed [SUMW-1:0]   sum_w;
    logic [SH_W-1:0]          coef_q;

    // fast sample moved to the slow-stream weight (sign kept by the MSB)
    assign x_s = {fast_in, {SCALE{1'b0}}};

    xb_delay #(.W(SLOW_W), .DEPTH(DLY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (x_s),
        .d_out (xd_w)
    );

    if (UP_MODE == xb_pkg::UP_HOLD) begin : g_hold
        logic [SLOW_W-1:0] hold_q;
        // keep the latest strobed slow sample
        always_ff @(posedge clk) begin
            if (!rst_n)        hold_q <= '0;
            else if (slow_vld) hold_q <= slow_in;
        end
        assign up_w = hold_q;
    end else begin : g_lin
        xb_lerp #(.W(SLOW_W), .RATIO(RATIO)) u_lerp (
            .clk   (clk),
            .rst_n (rst_n),
            .s_in  (slow_in),
            .s_vld (slow_vld),
            .s_out (up_w)
        );
    end

    xb_lpf #(.DW(SLOW_W), .SH_W(SH_W), .K_RST(K_RST), .FRAC_W(FRAC_W)) u_lpf (
        .clk     (clk),
        .rst_n   (rst_n),
        .coef_wr (coef_wr),
        .coef_in (coef_in),
        .x_in    (xd_w),
        .lp_out  (lp_w),
        .coef_q  (coef_q)
    );

    // complementary high-pass and blended sum
    always_comb begin
        hp_w  = $signed({{2{xd_w[SLOW_W-1]}}, xd_w}) - $signed(lp_w);
        sum_w = $signed({hp_w[HPW-1], hp_w}) + $signed({{3{up_w[SLOW_W-1]}}, up_w});
    end

    // saturating output register
    always_ff @(posedge clk) begin
        if (!rst_n)              blend_out <= '0;
        else if (sum_w > SAT_HI) blend_out <= SAT_HI[OUT_W-1:0];
        else if (sum_w < SAT_LO) blend_out <= SAT_LO[OUT_W-1:0];
        else                     blend_out <= sum_w[OUT_W-1:0];
    end

endmodule

// File: rtl/xover_blend_chk.sv
// Temporal checks for the crossover blender, bound to every instance.
// Assumes: signal names of the top module as connected by the bind below.
module xover_blend_chk #(
    parameter int SLOW_W = 18,
    parameter int OUT_W  = 18,
    parameter int SH_W   = 4,
    parameter xb_pkg::up_mode_e UP_MODE = xb_pkg::UP_HOLD
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_vld,
    input logic              coef_wr,
    input logic [SH_W-1:0]   coef_in,
    input logic [SH_W-1:0]   coef_q,
    input logic [SLOW_W-1:0] xd,
    input logic [SLOW_W+1:0] lp,
    input logic [SLOW_W+1:0] hp,
    input logic [SLOW_W-1:0] up,
    input logic [OUT_W-1:0]  blend_out
);

    // R1: reset clears the output
    p_reset_out_r1: assert property (@(posedge clk)
        !rst_n |=> blend_out == '0);

    // R7: a write lands on the next edge
    p_coef_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        coef_wr |=> coef_q == $past(coef_in));

    // R7: without a write the coefficient keeps its value
    p_coef_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_wr |=> $stable(coef_q));

    // R7: shift 0 makes the low-pass the previous aligned fast sample
    p_shift0_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_q == '0) |=> lp == {{2{$past(xd[SLOW_W-1])}}, $past(xd)});

    // R8: two non-negative parts never produce a negative output
    p_no_wrap_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp[SLOW_W+1] && !up[SLOW_W-1]) |=> !blend_out[OUT_W-1]);

    // R8: two negative parts never produce a non-negative output
    p_no_wrap_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hp[SLOW_W+1] && up[SLOW_W-1]) |=> blend_out[OUT_W-1]);

    if (UP_MODE == xb_pkg::UP_HOLD) begin : g_hold_chk
        // R3: no strobe, no change of the held slow sample
        p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !slow_vld |=> $stable(up));
    end

endmodule

bind xover_blend xover_blend_chk #(
    .SLOW_W  (SLOW_W),
    .OUT_W   (OUT_W),
    .SH_W    (SH_W),
    .UP_MODE (UP_MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_vld  (slow_vld),
    .coef_wr   (coef_wr),
    .coef_in   (coef_in),
    .coef_q    (coef_q),
    .xd        (xd_w),
    .lp        (lp_w),
    .hp        (hp_w),
    .up        (up_w),
    .blend_out (blend_out)
);

// File: tb/xover_blend_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module xover_blend_test;

    logic        clk      = 1'b0;
    logic        rst_n    = 1'b0;
    logic [9:0]  fast_in  = '0;
    logic [17:0] slow_in  = '0;
    logic        slow_vld = 1'b0;
    logic        coef_wr  = 1'b0;
    logic [3:0]  coef_in  = '0;
    logic [17:0] blend_out;
    logic [17:0] lin_out;
    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    xover_blend uut (
        .clk(clk), .rst_n(rst_n), .fast_in(fast_in), .slow_in(slow_in),
        .slow_vld(slow_vld), .coef_wr(coef_wr), .coef_in(coef_in),
        .blend_out(blend_out)
    );

    xover_blend #(.UP_MODE(xb_pkg::UP_LINEAR)) uut_lin (
        .clk(clk), .rst_n(rst_n), .fast_in(fast_in), .slow_in(slow_in),
        .slow_vld(slow_vld), .coef_wr(coef_wr), .coef_in(coef_in),
        .blend_out(lin_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, got, exp);
        end
    endtask

    function automatic int sv(input logic [17:0] v);
        return $signed(v);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; fast_in = '0; slow_in = '0; slow_vld = 1'b0; coef_wr = 1'b0;
        repeat (3) tick();
        chk("R1 reset output", sv(blend_out), 0);
        chk("R1 reset output (linear)", sv(lin_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic write_coef(input int k);
        coef_wr = 1'b1; coef_in = 4'(k);
        tick();
        coef_wr = 1'b0;
    endtask

    task automatic present_slow(input int v);
        slow_in = 18'(v); slow_vld = 1'b1;
    endtask

    // R2 and R7: scaling of a negative fast code, one-sample response at shift 0
    task automatic t_scale_shift0();
        do_reset();
        write_coef(0);
        fast_in = 10'(-3);
        tick();
        tick();
        chk("R2 fast weight", sv(blend_out), -768);
        tick();
        chk("R7 shift0 single sample", sv(blend_out), 0);
    endtask

    // R4: joint arrival of fast and slow steps
    task automatic t_align();
        do_reset();
        fast_in = 10'(50); present_slow(7000);
        tick();
        slow_vld = 1'b0;
        chk("R4 nothing after first edge", sv(blend_out), 0);
        tick();
        chk("R4 both paths together", sv(blend_out), 12800 + 7000);
    endtask

    // R5 and R1: fast-only step with the reset coefficient
    task automatic t_fast_step();
        int prev;
        int mono_bad;
        do_reset();
        fast_in = 10'(100);
        tick();
        tick();
        chk("R5 first sample", sv(blend_out), 25600);
        tick();
        chk("R1 default shift second sample", sv(blend_out), 24000);
        tick();
        chk("R5 third sample", sv(blend_out), 22500);
        prev = sv(blend_out);
        mono_bad = 0;
        for (int i = 0; i < 1000; i++) begin
            tick();
            if (sv(blend_out) > prev || sv(blend_out) < 0) mono_bad++;
            prev = sv(blend_out);
        end
        chk("R5 monotone decay", mono_bad, 0);
        chk("R5 final zero", sv(blend_out), 0);
    endtask

    // R6, R9 and R3: unity at steady state, coefficient change, hold
    task automatic t_unity_hold();
        int drift;
        do_reset();
        write_coef(6);
        fast_in = 10'(-37); present_slow(-9472);
        tick();
        slow_vld = 1'b0;
        repeat (3000) tick();
        chk("R6 settle shift 6", sv(blend_out), -9472);
        write_coef(1);
        drift = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (sv(blend_out) != -9472) drift++;
        end
        write_coef(5);
        for (int i = 0; i < 20; i++) begin
            tick();
            if (sv(blend_out) != -9472) drift++;
        end
        chk("R9 no step on coefficient change", drift, 0);
        slow_in = 18'(5000);
        repeat (5) tick();
        chk("R3 slow ignored without strobe", sv(blend_out), -9472);
        present_slow(-9216);
        tick();
        slow_vld = 1'b0;
        chk("R3 not yet after one edge", sv(blend_out), -9472);
        tick();
        chk("R3 new slow after two edges", sv(blend_out), -9216);

        do_reset();
        write_coef(2);
        fast_in = 10'(211); present_slow(54016);
        tick();
        slow_vld = 1'b0;
        repeat (600) tick();
        chk("R6 settle shift 2", sv(blend_out), 54016);
    endtask

    // R8: saturation at both rails
    task automatic t_sat();
        do_reset();
        fast_in = 10'(511); present_slow(131071);
        tick();
        slow_vld = 1'b0;
        tick();
        chk("R8 positive rail", sv(blend_out), 131071);
        do_reset();
        fast_in = 10'(-512); present_slow(-131072);
        tick();
        slow_vld = 1'b0;
        tick();
        chk("R8 negative rail", sv(blend_out), -131072);
    endtask

    // R10: linear upsampling ramp in the second instance
    task automatic t_lerp();
        do_reset();
        present_slow(8000);
        tick();
        slow_vld = 1'b0;
        tick();
        chk("R3 hold instance after two edges", sv(blend_out), 8000);
        tick();
        chk("R10 ramp edge 3", sv(lin_out), 1000);
        repeat (3) tick();
        chk("R10 ramp edge 6", sv(lin_out), 4000);
        repeat (4) tick();
        chk("R10 ramp edge 10", sv(lin_out), 8000);
        repeat (4) tick();
        chk("R10 holds after ramp", sv(lin_out), 8000);
    endtask

    initial begin
        t_scale_shift0();
        t_align();
        t_fast_step();
        t_unity_hold();
        t_sat();
        t_lerp();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule